// File: doc/BRIEF.md
# Shared-Memory Multi-Queue Manager

This block manages 64 hardware FIFO queues that all live in one on-chip SRAM. A bus requester pushes an entry by writing a queue's access window and pops one by reading it. Each queue has an entry size of one, two or four 32-bit words. The access addresses hold no data of their own. Each word access is turned into an SRAM access at the queue's current write or read slot. The manager keeps a read pointer and a write pointer for every queue. From them it derives four flags per queue: full, nearly full, nearly empty and empty.

The flags of queues 0 to 31 can be read as four packed status words. For setup and test, these words can also be written. Such a write only loads a shadow copy, and that copy is shown in place of the live flags until the next access-window access.

The request side is a valid/ready channel. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high. The response side carries no back-pressure. Every accepted read produces exactly one `rsp_valid` pulse in the next cycle, and the requester must take the data in that cycle. Each queue's entry size is a static configuration input.

Top module: `qmgr_top`

## Requirements
- R1: The access window of queue n, for n from 0 to 63, covers byte offsets 16n to 16n+15, and word x of an entry sits at offset 16n+4x.
- R2: `qsize_cfg[2n+1:2n]` sets the entry size of queue n: 0 means 1 word, 1 means 2 words, 2 or 3 means 4 words. An access to a word index at or beyond the entry size is ignored: a write stores nothing, a read returns 0, and neither moves a pointer.
- R3: An entry is pushed when its last valid word is written and popped when its last valid word is read. Each queue returns its entries in the order they were pushed, with the words that were written.
- R4: `req_ready` is always 1. An accepted read produces `rsp_valid` = 1 with its data in the next cycle. Any other cycle gives `rsp_valid` = 0 in the following cycle.
- R5: A read from an empty queue returns 0 and leaves that queue's state unchanged.
- R6: Each queue holds 16 entries. A write to a full queue is dropped, and the stored entries stay intact.
- R7: Each queue's status nibble has bit 3 = full (16 entries), bit 2 = nearly full (15 or more), bit 1 = nearly empty (1 or fewer) and bit 0 = empty (0 entries).
- R8: Status word n, for n from 0 to 3, is at offset 0x400+4n. It holds queue 8n+k in bits 4k+3:4k. After reset, all four words read 0x33333333.
- R9: A write to a status word loads only its shadow copy. That word then reads back the written value until any access-window access occurs, after which it shows the live flags again. The write never changes queue contents or pointers.
- R10: A read of any other address, including addresses that are not word aligned, returns 0. A write there has no effect.
- R11: Operations on one queue leave the contents and flags of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (held high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| qsize_cfg | input | 128 | Entry size code, 2 bits per queue |

## Verification
Queues of every entry size are driven with interleaved single-word and multi-word traffic. This shows whether commit happens only on the last valid word and whether out-of-range word indexes stay inert. One queue is filled through the 1, 2, 15 and 16 entry levels and then over-filled and drained. That sequence separates the four flag thresholds, dropped pushes and empty pops. A shadow-write sequence placed around queue accesses tells a shadow that lingers apart from one that is cleared, and a status write that touches real state apart from one that does not.

// File: rtl/qmgr_pkg.sv
package qmgr_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_LANE = 2'd1,
    SRC_STAT = 2'd2
  } rsp_src_e;

  // index of the last valid word for a size code
  function automatic logic [1:0] last_word(input logic [1:0] code);
    case (code)
      2'd0:    last_word = 2'd0;
      2'd1:    last_word = 2'd1;
      default: last_word = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/qmgr_decode.sv
module qmgr_decode #(
  parameter int NQ        = 64,
  parameter int ADDR_W    = 11,
  parameter int STAT_BASE = 'h400,
  parameter int NREG      = 4,
  localparam int QW = $clog2(NQ),
  localparam int SW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2*NQ-1:0]   cfg,
  output logic              is_win,
  output logic              is_stat,
  output logic [QW-1:0]     qidx,
  output logic [1:0]        widx,
  output logic [SW-1:0]     sidx,
  output logic              in_range,
  output logic              is_last
);
  import qmgr_pkg::*;

  localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(NQ * 16);
  localparam logic [ADDR_W-1:0] SBASE    = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] SSPAN    = ADDR_W'(4 * NREG);

  logic [ADDR_W-1:0] soff;
  logic [1:0]        code;
  logic [1:0]        lastw;
  logic              aligned;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    soff     = addr - SBASE;
    is_win   = aligned && (addr < WIN_END);
    is_stat  = aligned && (addr >= SBASE) && (soff < SSPAN);
    qidx     = addr[QW+3:4];
    widx     = addr[3:2];
    sidx     = soff[SW+1:2];
    code     = cfg[2*qidx +: 2];
    lastw    = last_word(code);
    in_range = (widx <= lastw);
    is_last  = (widx == lastw);
  end
endmodule

// File: rtl/qmgr_ptrs.sv
module qmgr_ptrs #(
  parameter int NQ    = 64,
  parameter int DEPTH = 16,
  parameter int NE_TH = 1,
  parameter int NF_TH = 15,
  localparam int QW = $clog2(NQ),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [QW-1:0] qidx,
  output logic [PW-1:0] wr_slot,
  output logic [PW-1:0] rd_slot,
  output logic          sel_full,
  output logic          sel_empty,
  output logic [4*NQ-1:0] flags
);
  logic [PW:0] wptr [NQ];
  logic [PW:0] rptr [NQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        wptr[i] <= '0;
        rptr[i] <= '0;
      end
    end else begin
      if (push) wptr[qidx] <= wptr[qidx] + 1'b1;
      if (pop)  rptr[qidx] <= rptr[qidx] + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_flag
      logic [PW:0] cnt;
      always_comb begin
        cnt = wptr[g] - rptr[g];
        flags[4*g+3] = (cnt == (PW+1)'(DEPTH));
        flags[4*g+2] = (cnt >= (PW+1)'(NF_TH));
        flags[4*g+1] = (cnt <= (PW+1)'(NE_TH));
        flags[4*g]   = (cnt == '0);
      end
    end
  endgenerate

  always_comb begin
    wr_slot   = wptr[qidx][PW-1:0];
    rd_slot   = rptr[qidx][PW-1:0];
    sel_full  = flags[4*qidx+3];
    sel_empty = flags[4*qidx];
  end
endmodule

// File: rtl/qmgr_lane.sv
module qmgr_lane #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1 << AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/qmgr_status.sv
module qmgr_status #(
  parameter int NQ   = 64,
  parameter int NREG = 4,
  parameter int DW   = 32,
  localparam int SW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [SW-1:0]   sidx,
  input  logic [DW-1:0]   wdata,
  input  logic            clear,
  input  logic [4*NQ-1:0] flags,
  output logic [DW-1:0]   rd_word
);
  localparam logic [DW-1:0] RST_VAL = {(DW/4){4'h3}};

  logic [DW-1:0]   shadow [NREG];
  logic [NREG-1:0] shsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= RST_VAL;
      shsel <= '0;
    end else if (clear) begin
      shsel <= '0;
    end else if (wr) begin
      shadow[sidx] <= wdata;
      shsel[sidx]  <= 1'b1;
    end
  end

  always_comb begin
    if (shsel[sidx]) rd_word = shadow[sidx];
    else             rd_word = flags[sidx*DW +: DW];
  end
endmodule

// File: rtl/qmgr_top.sv
module qmgr_top #(
  parameter int NQ        = 64,
  parameter int DEPTH     = 16,
  parameter int DW        = 32,
  parameter int MAXW      = 4,
  parameter int NE_TH     = 1,
  parameter int NF_TH     = 15,
  parameter int ADDR_W    = 11,
  parameter int STAT_BASE = 'h400,
  parameter int STAT_Q    = 32,
  localparam int QW   = $clog2(NQ),
  localparam int PW   = $clog2(DEPTH),
  localparam int NREG = STAT_Q / (DW / 4),
  localparam int SW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [2*NQ-1:0]   qsize_cfg
);
  import qmgr_pkg::*;

  logic          is_win, is_stat, in_range, is_last;
  logic [QW-1:0] qidx;
  logic [1:0]    widx;
  logic [SW-1:0] sidx;
  logic [PW-1:0] wr_slot, rd_slot;
  logic          sel_full, sel_empty;
  logic [4*NQ-1:0] all_flags;
  logic          win_wr_ok, win_rd_ok, push, pop;
  logic [DW-1:0] stat_word;
  logic [DW-1:0] lane_q [MAXW];
  logic [QW+PW-1:0] mem_addr;

  rsp_src_e      rsrc;
  logic [1:0]    rlane;
  logic [DW-1:0] rstat;

  assign req_ready = 1'b1;

  qmgr_decode #(.NQ(NQ), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE), .NREG(NREG)) u_dec (
    .addr(req_addr), .cfg(qsize_cfg), .is_win(is_win), .is_stat(is_stat),
    .qidx(qidx), .widx(widx), .sidx(sidx), .in_range(in_range), .is_last(is_last)
  );

  always_comb begin
    win_wr_ok = req_valid && req_write && is_win && in_range && !sel_full;
    win_rd_ok = req_valid && !req_write && is_win && in_range && !sel_empty;
    push      = win_wr_ok && is_last;
    pop       = win_rd_ok && is_last;
    mem_addr  = req_write ? {qidx, wr_slot} : {qidx, rd_slot};
  end

  qmgr_ptrs #(.NQ(NQ), .DEPTH(DEPTH), .NE_TH(NE_TH), .NF_TH(NF_TH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .qidx(qidx),
    .wr_slot(wr_slot), .rd_slot(rd_slot), .sel_full(sel_full),
    .sel_empty(sel_empty), .flags(all_flags)
  );

  genvar g;
  generate
    for (g = 0; g < MAXW; g++) begin : g_lane
      qmgr_lane #(.AW(QW+PW), .DW(DW)) u_lane (
        .clk(clk),
        .we(win_wr_ok && (widx == 2'(g))),
        .re(win_rd_ok && (widx == 2'(g))),
        .addr(mem_addr),
        .wdata(req_wdata),
        .rdata(lane_q[g])
      );
    end
  endgenerate

  qmgr_status #(.NQ(NQ), .NREG(NREG), .DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .wr(req_valid && req_write && is_stat),
    .sidx(sidx), .wdata(req_wdata),
    .clear(req_valid && is_win),
    .flags(all_flags), .rd_word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsrc      <= SRC_ZERO;
      rlane     <= '0;
      rstat     <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rlane     <= widx;
      rstat     <= stat_word;
      if (win_rd_ok)                       rsrc <= SRC_LANE;
      else if (req_valid && is_stat)       rsrc <= SRC_STAT;
      else                                 rsrc <= SRC_ZERO;
    end
  end

  always_comb begin
    case (rsrc)
      SRC_LANE: rsp_rdata = lane_q[rlane];
      SRC_STAT: rsp_rdata = rstat;
      default:  rsp_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qmgr_chk.sv
module qmgr_chk #(
  parameter int NQ = 64,
  parameter int DW = 32,
  localparam int QW = $clog2(NQ)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_rdata,
  input logic            is_win,
  input logic            sel_full,
  input logic            sel_empty,
  input logic [QW-1:0]   qidx,
  input logic [4*NQ-1:0] flags
);
  logic [NQ-1:0] full_vec;
  logic          bad_combo;

  always_comb begin
    bad_combo = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      full_vec[i] = flags[4*i+3];
      if (flags[4*i+3] && !flags[4*i+2]) bad_combo = 1'b1;
      if (flags[4*i]   && !flags[4*i+1]) bad_combo = 1'b1;
      if (flags[4*i+3] &&  flags[4*i])   bad_combo = 1'b1;
      if (flags[4*i+2] &&  flags[4*i+1]) bad_combo = 1'b1;
    end
  end

  p_rsp_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_no_spurious_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_win && sel_empty) |=> (rsp_rdata == '0));

  p_full_push_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && is_win && sel_full) |=> full_vec[$past(qidx)]);

  p_flag_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_combo);
endmodule

bind qmgr_top qmgr_chk #(.NQ(NQ), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .is_win(is_win),
  .sel_full(sel_full), .sel_empty(sel_empty), .qidx(qidx), .flags(all_flags)
);

// File: tb/sim_qmgr_top.sv
module sim_qmgr_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic        wr;
    logic [10:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 11'h050, 32'h000000A1},
    '{1'b1, 11'h050, 32'h000000A2},
    '{1'b1, 11'h054, 32'h000000DD},
    '{1'b1, 11'h060, 32'h000000B0},
    '{1'b1, 11'h064, 32'h000000B1},
    '{1'b0, 11'h400, 32'h32033333},
    '{1'b0, 11'h054, 32'h00000000},
    '{1'b0, 11'h050, 32'h000000A1},
    '{1'b0, 11'h060, 32'h000000B0},
    '{1'b0, 11'h064, 32'h000000B1},
    '{1'b0, 11'h050, 32'h000000A2},
    '{1'b0, 11'h050, 32'h00000000},
    '{1'b1, 11'h070, 32'h000000C0},
    '{1'b1, 11'h074, 32'h000000C1},
    '{1'b1, 11'h078, 32'h000000C2},
    '{1'b1, 11'h07C, 32'h000000C3},
    '{1'b0, 11'h400, 32'h23333333},
    '{1'b0, 11'h070, 32'h000000C0},
    '{1'b0, 11'h074, 32'h000000C1},
    '{1'b0, 11'h078, 32'h000000C2},
    '{1'b0, 11'h07C, 32'h000000C3},
    '{1'b1, 11'h080, 32'h000000D0},
    '{1'b1, 11'h084, 32'h000000D1},
    '{1'b1, 11'h088, 32'h000000D2},
    '{1'b1, 11'h08C, 32'h000000D3},
    '{1'b0, 11'h080, 32'h000000D0},
    '{1'b0, 11'h084, 32'h000000D1},
    '{1'b0, 11'h088, 32'h000000D2},
    '{1'b0, 11'h08C, 32'h000000D3},
    '{1'b0, 11'h080, 32'h00000000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [10:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [127:0] qsize_cfg;

  int checks = 0;
  int errors = 0;
  logic        rv;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  qmgr_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .qsize_cfg(qsize_cfg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    rv = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [10:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    rv = rsp_valid; rd = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [10:0] a, input logic [31:0] exp);
    bus_rd(a);
    check({tag, " rsp_valid R4"}, {31'd0, rv}, 32'd1);
    check(tag, rd, exp);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    qsize_cfg = '0;
    qsize_cfg[13:12] = 2'd1;   // queue 6: 2 words
    qsize_cfg[15:14] = 2'd3;   // queue 7: 4 words (code 3)
    qsize_cfg[17:16] = 2'd2;   // queue 8: 4 words (code 2)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R8
    check("R4 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R4 req_ready", {31'd0, req_ready}, 32'd1);
    for (int r = 0; r < 4; r++)
      rd_chk("R8 status reset", 11'h400 + 11'(4*r), 32'h33333333);

    // table walk: R1 R2 R3 R7 R11
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].data);
      else rd_chk($sformatf("R3 R2 R11 vector %0d", i), VEC[i].addr, VEC[i].data);
    end

    bus_wr(11'h050, 32'h1);
    check("R4 no rsp after write", {31'd0, rv}, 32'd0);
    bus_rd(11'h050);

    // queue 63 window, R1
    bus_wr(11'h3F0, 32'h00000063);
    rd_chk("R1 queue 62 empty", 11'h3E0, 32'h0);
    rd_chk("R1 queue 63", 11'h3F0, 32'h00000063);

    // fill queue 9, thresholds R7 and overflow R6
    bus_wr(11'h090, 32'h100);
    rd_chk("R7 one entry", 11'h404, 32'h33333323);
    bus_wr(11'h090, 32'h101);
    rd_chk("R7 two entries", 11'h404, 32'h33333303);
    for (int k = 2; k < 15; k++) bus_wr(11'h090, 32'h100 + 32'(k));
    rd_chk("R7 fifteen entries", 11'h404, 32'h33333343);
    bus_wr(11'h090, 32'h10F);
    rd_chk("R7 full", 11'h404, 32'h333333C3);
    bus_wr(11'h090, 32'hFFFF);
    rd_chk("R6 still full", 11'h404, 32'h333333C3);
    for (int k = 0; k < 16; k++)
      rd_chk($sformatf("R6 drain %0d", k), 11'h090, 32'h100 + 32'(k));
    rd_chk("R5 empty pop", 11'h090, 32'h0);
    rd_chk("R5 state unchanged", 11'h404, 32'h33333333);

    // shadow, R9
    bus_wr(11'h000, 32'h77);
    bus_wr(11'h400, 32'hFFFF0000);
    rd_chk("R9 shadow readback", 11'h400, 32'hFFFF0000);
    rd_chk("R9 other word live", 11'h404, 32'h33333333);
    bus_wr(11'h408, 32'hAAAA5555);
    rd_chk("R9 second shadow", 11'h408, 32'hAAAA5555);
    rd_chk("R9 queue state kept", 11'h000, 32'h77);
    rd_chk("R9 live after access", 11'h400, 32'h33333333);
    rd_chk("R9 word2 live after access", 11'h408, 32'h33333333);

    // other addresses, R10
    bus_wr(11'h410, 32'h1);
    rd_chk("R10 unmapped", 11'h410, 32'h0);
    rd_chk("R10 high unmapped", 11'h7FC, 32'h0);
    bus_wr(11'h402, 32'h12345678);
    rd_chk("R10 unaligned ignored", 11'h400, 32'h33333333);
    rd_chk("R10 word3 live", 11'h40C, 32'h33333333);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule